// File: doc/BRIEF.md
# Retry Timeout Status Monitor

This block watches three independent retry channels of a bus bridge: one host-bus target and two card-bus targets, called A and B. Each time the bridge answers a requesting master with a retry, the channel's timeout counter starts. If that master does not come back before the counter reaches its limit, a sticky expiration flag is raised for the channel. The default limit is 2^15 = 32768 bus clocks.

The flags and the two counter enables live in one 8-bit control/status word. Software reaches this word through a simple select/write/address port at configuration offset 0x90. A flag is cleared by writing a 1 to its bit. A flag that hardware raises in the same cycle as a clearing write stays set, so no expiration is lost.

Channels are indexed 0 = host, 1 = card A, 2 = card B on the per-channel pulse inputs.

Top module: `retry_watch_top`

## Requirements
- R1: After reset, a read at offset 0x90 returns 0xC0, meaning both enables are on and every flag is clear.
- R2: A retry pulse on an enabled channel that is followed by no return pulse sets that channel's flag. The flag sets on the clock edge that comes TIMEOUT_CYC edges after the edge that sampled the retry (default 32768).
- R3: A return pulse sampled on any of edges 1 to TIMEOUT_CYC after the retry stops the counter and clears it, and no flag is set. This includes the limit edge itself.
- R4: The flag bits are fixed: host at bit 1, card A at bit 3, card B at bit 5. Bit 7 enables the host counter. Bit 6 enables both card counters.
- R5: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R6: Bits 4, 2 and 0 always read 0, and writes to them have no effect.
- R7: While a channel's enable is 0, its counter is held at zero and cannot set its flag. A flag that is already set stays set. Clearing an enable in the middle of a count cancels that episode.
- R8: If a flag is raised by hardware and cleared by a write on the same edge, it ends up set.
- R9: The counter saturates at the limit, and it raises the flag only once per retry episode. A retry pulse that arrives while counting restarts the count from that edge.
- R10: Accesses at any offset other than 0x90 read 0 and change nothing.
- R11: Both enable bits can be written and read back, with 1 meaning enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_issued | input | 3 | One-cycle pulse per channel: a retry was issued to the master |
| master_back | input | 3 | One-cycle pulse per channel: the retried master returned |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read, valid with reg_sel |
| reg_addr | input | 8 | Configuration offset of the access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: the status word when the offset matches, otherwise 0 |

## Verification
A pulse sampled at edge 0 raises its flag at edge TIMEOUT_CYC. The flag is visible on the combinational read path within that same cycle. A register write takes effect at its sampling edge, and an enable change reaches the counter one edge later. The bench drives every input at the falling edge and reads half a cycle after an edge. It counts edges from the one that sampled the retry and checks both one edge before the due edge and just after it. The return, set-versus-clear and restart cases are placed on the exact limit edge so that an off-by-one in the counter shows up.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

    localparam int N_CH = 3;

    typedef enum logic [1:0] {
        CH_HOST   = 2'd0,
        CH_CARD_A = 2'd1,
        CH_CARD_B = 2'd2
    } chan_e;

    localparam int         EN_HOST_BIT = 7;
    localparam int         EN_CARD_BIT = 6;
    localparam logic [7:0] WORD_RESET  = 8'hC0;

    // status word bit that holds the expiration flag of a channel
    function automatic int flag_pos(input int ch);
        return 2 * ch + 1;
    endfunction

endpackage

// File: rtl/retry_tmr.sv
module retry_tmr #(
    parameter int LIMIT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic retry_pls,
    input  logic back_pls,
    output logic expire_pls
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;
    logic hit_limit;

    always_comb begin
        s_d        = s_q;
        hit_limit  = s_q.run && (s_q.cnt == CNT_MAX);
        expire_pls = enable && hit_limit && !back_pls;
        if (!enable) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (retry_pls) begin
            s_d.run = 1'b1;
            s_d.cnt = CNT_W'(1);
        end else if (back_pls) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (s_q.run) begin
            if (hit_limit) begin
                s_d.run = 1'b0;          // saturate, episode done
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_MAX);
    a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (s_q.cnt == '0 && !s_q.run));
    a_r9_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_pls && !retry_pls) |=> !expire_pls);
    a_r3_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && back_pls && !retry_pls) |=> (s_q.cnt == '0));

endmodule

// File: rtl/retry_stat_reg.sv
module retry_stat_reg
    import rtw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [7:0]      wdata,
    input  logic [N_CH-1:0] set_flags,
    output logic            en_host,
    output logic            en_card,
    output logic [7:0]      rd_word
);
    typedef struct packed {
        logic            en_h;
        logic            en_c;
        logic [N_CH-1:0] flags;
    } stat_s;

    stat_s r_d, r_q;
    logic [N_CH-1:0] clr_mask;

    always_comb begin
        for (int ch = 0; ch < N_CH; ch++) begin
            clr_mask[ch] = wr_hit && wdata[flag_pos(ch)];
        end
        r_d = r_q;
        if (wr_hit) begin
            r_d.en_h = wdata[EN_HOST_BIT];
            r_d.en_c = wdata[EN_CARD_BIT];
        end
        // hardware set overrides a same-cycle clear
        r_d.flags = (r_q.flags & ~clr_mask) | set_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en_h  <= WORD_RESET[EN_HOST_BIT];
            r_q.en_c  <= WORD_RESET[EN_CARD_BIT];
            r_q.flags <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_word              = '0;
        rd_word[EN_HOST_BIT] = r_q.en_h;
        rd_word[EN_CARD_BIT] = r_q.en_c;
        for (int ch = 0; ch < N_CH; ch++) begin
            rd_word[flag_pos(ch)] = r_q.flags[ch];
        end
    end

    assign en_host = r_q.en_h;
    assign en_card = r_q.en_c;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags != '0) |=> ((r_q.flags & $past(set_flags)) == $past(set_flags)));
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.flags & $past(r_q.flags & ~clr_mask)) == $past(r_q.flags & ~clr_mask)));
    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word & 8'h15) == 8'h00);

endmodule

// File: rtl/retry_watch_top.sv
module retry_watch_top
    import rtw_pkg::*;
#(
    parameter int         TIMEOUT_CYC = 32768,
    parameter logic [7:0] REG_OFFSET  = 8'h90
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] retry_issued,
    input  logic [N_CH-1:0] master_back,
    input  logic            reg_sel,
    input  logic            reg_wr,
    input  logic [7:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata
);
    logic            acc_hit;
    logic            wr_hit;
    logic            en_host;
    logic            en_card;
    logic [7:0]      word;
    logic [N_CH-1:0] ch_en;
    logic [N_CH-1:0] expire;

    assign acc_hit   = reg_sel && (reg_addr == REG_OFFSET);
    assign wr_hit    = acc_hit && reg_wr;
    assign reg_rdata = acc_hit ? word : 8'h00;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        if (g == int'(CH_HOST)) begin : g_host_en
            assign ch_en[g] = en_host;
        end else begin : g_card_en
            assign ch_en[g] = en_card;
        end

        retry_tmr #(
            .LIMIT(TIMEOUT_CYC)
        ) i_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (ch_en[g]),
            .retry_pls (retry_issued[g]),
            .back_pls  (master_back[g]),
            .expire_pls(expire[g])
        );
    end

    retry_stat_reg i_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wdata    (reg_wdata),
        .set_flags(expire),
        .en_host  (en_host),
        .en_card  (en_card),
        .rd_word  (word)
    );

    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_addr != REG_OFFSET) |-> (reg_rdata == 8'h00));
    a_r7_no_expiry_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (expire & ~ch_en) == '0);

endmodule

// File: tb/test_retry_watch_top.sv
`timescale 1ns/100ps
module test_retry_watch_top;
    localparam int LIM = 16;
    localparam logic [7:0] OFS = 8'h90;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] retry_issued = '0;
    logic [2:0] master_back = '0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    retry_watch_top #(.TIMEOUT_CYC(LIM), .REG_OFFSET(OFS)) i_retry_watch_top (
        .clk(clk), .rst_n(rst_n), .retry_issued(retry_issued),
        .master_back(master_back), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [2:0] rty;
        logic [2:0] bk;
        logic [7:0] bk_at;
        logic [7:0] exp;
    } vec_t;

    // R2/R3/R4 vectors: retry mask, return mask, return edge, expected word
    localparam vec_t VECS [6] = '{
        '{3'b001, 3'b000, 8'd0,  8'hC2},
        '{3'b010, 3'b000, 8'd0,  8'hC8},
        '{3'b100, 3'b000, 8'd0,  8'hE0},
        '{3'b111, 3'b010, 8'd5,  8'hE2},
        '{3'b001, 3'b001, 8'd16, 8'hC0},
        '{3'b011, 3'b001, 8'd15, 8'hC8}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [7:0] addr, input logic [7:0] exp);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = addr;
        #1;
        check(req, reg_rdata, exp);
        reg_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd_check("R1 reset word", OFS, 8'hC0);
        rst_n = 1'b1;
        step();
        rd_check("R1 word after release", OFS, 8'hC0);
        rd_check("R10 other offset reads zero", 8'h91, 8'h00);

        // table walk
        for (int v = 0; v < 6; v++) begin
            retry_issued = VECS[v].rty;
            step();
            retry_issued = '0;
            for (int k = 1; k <= LIM + 2; k++) begin
                if (VECS[v].bk != 0 && k == int'(VECS[v].bk_at)) master_back = VECS[v].bk;
                step();
                master_back = '0;
            end
            rd_check($sformatf("R2/R3/R4 vector %0d", v), OFS, VECS[v].exp);
            wr(OFS, 8'hEA);
            rd_check("R5 clear after vector", OFS, 8'hC0);
        end

        // R2 timing edge: not set one edge early
        retry_issued = 3'b001;
        step();
        retry_issued = '0;
        for (int k = 1; k < LIM; k++) step();
        rd_check("R2 not set before limit edge", OFS, 8'hC0);
        step();
        rd_check("R2 set at limit edge", OFS, 8'hC2);

        // R5 writing zero keeps the flag
        wr(OFS, 8'hC0);
        rd_check("R5 zero write keeps flag", OFS, 8'hC2);
        wr(OFS, 8'hC2);
        rd_check("R5 one write clears flag", OFS, 8'hC0);

        // R6 reserved bits
        wr(OFS, 8'h15);
        rd_check("R6 reserved writes ignored", OFS, 8'h00);
        wr(OFS, 8'hFF);
        rd_check("R6 all ones write", OFS, 8'hC0);

        // R10 miss write
        wr(8'h91, 8'h00);
        rd_check("R10 miss write ignored", OFS, 8'hC0);

        // R11 enables read/write
        wr(OFS, 8'h80);
        rd_check("R11 host only enabled", OFS, 8'h80);
        wr(OFS, 8'hC0);

        // R7 host disabled, card A still counts
        wr(OFS, 8'h40);
        retry_issued = 3'b011;
        step();
        retry_issued = '0;
        for (int k = 1; k <= LIM + 4; k++) step();
        rd_check("R7 disabled channel no flag", OFS, 8'h48);
        wr(OFS, 8'h00);
        rd_check("R7 set flag survives disable", OFS, 8'h08);
        wr(OFS, 8'hC8);
        rd_check("R7 restore", OFS, 8'hC0);

        // R7 disable mid-count cancels episode
        retry_issued = 3'b001;
        step();
        retry_issued = '0;
        for (int k = 1; k <= LIM + 10; k++) begin
            if (k == 5) begin
                wr(OFS, 8'h40);
            end else if (k == 8) begin
                wr(OFS, 8'hC0);
            end else begin
                step();
            end
        end
        rd_check("R7 mid-count disable cancels", OFS, 8'hC0);

        // R8 set beats a same-edge clear
        retry_issued = 3'b001;
        step();
        retry_issued = '0;
        for (int k = 1; k < LIM; k++) step();
        wr(OFS, 8'hC2);
        rd_check("R8 set wins over clear", OFS, 8'hC2);

        // R9 once per episode
        wr(OFS, 8'hC2);
        for (int k = 0; k < 2 * LIM; k++) step();
        rd_check("R9 no second flag in saturation", OFS, 8'hC0);

        // R9 restart by a second retry
        retry_issued = 3'b100;
        step();
        retry_issued = '0;
        for (int k = 1; k <= 25; k++) begin
            if (k == 10) retry_issued = 3'b100;
            step();
            retry_issued = '0;
            if (k == LIM + 2) rd_check("R9 restart delays flag", OFS, 8'hC0);
        end
        rd_check("R9 not set one edge before restarted limit", OFS, 8'hC0);
        step();
        rd_check("R9 set at restarted limit", OFS, 8'hE0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule